// File: doc/BRIEF.md
# I2C Slave Pointer Register Interface

This block is the serial front end of a small I2C target that exposes three byte-wide registers. It watches synchronously sampled SCL and SDA lines, recognises START, repeated START and STOP, and matches the address byte against a seven-bit address. The upper three bits of that address are fixed and the lower four come from strap inputs. The first byte written after a matching address is a command byte. It carries a two-bit register pointer and an auto-increment flag. Later bytes are written to or read from the register that the pointer selects.

The registers themselves live outside the block, on a simple register bus: a pointer-driven address, a write-data byte with a one-cycle write strobe, and a combinational read-data return. The block decides ACK or NACK for every byte it receives. It drives SDA only through an open-drain enable, which pulls the line low when set. The stored pointer survives STOP and repeated START, so a read that starts after a command write continues from the selected register. Glitch filtering and clock stretching are not part of this block.

Top module: `i2c_ptr_regif`

## Requirements
- R1: An address byte is acknowledged exactly when its upper seven bits equal binary 111 followed by `strap_i[3:0]`; bit 0 selects read (1) or write (0). On a mismatch SDA stays released and every following byte is ignored, with no ACK and no register strobe, until the next START.
- R2: A command byte is acknowledged and stored only when bits 7:5 and 3:2 are zero and bits 1:0 are 00, 01 or 10. Bits 1:0 become the pointer and bit 4 becomes the auto-increment flag. Any other command byte is refused with NACK, leaves the stored command unchanged, and causes the rest of the transfer to be ignored.
- R3: A data byte written while the pointer is 00 or 01 is acknowledged and produces exactly one `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: A data byte written while the pointer is 10 (read-only status) is refused with NACK, produces no `reg_we` pulse, and the rest of the transfer is ignored.
- R5: With auto-increment set, each accepted written byte moves the pointer 00 to 01 to 10. At 10 the pointer stays put and does not wrap on the write path.
- R6: Read bytes are sent MSB first from `reg_rdata` while `reg_addr` shows the pointer. With auto-increment set, the pointer advances after each byte sent, going 00 to 01 to 10 to 00. Without it, the same register is sent again.
- R7: When the master does not acknowledge a read byte, SDA is released and stays released until the next START.
- R8: The pointer resets to 00 with auto-increment clear. STOP and repeated START keep its value, and `reg_addr` shows it between transfers.
- R9: `sda_oe` is asserted only while SCL is low, and it is cleared by START and STOP.
- R10: After reset, `sda_oe` and `reg_we` are low.

Port names, widths and directions:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used to sample the bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_i | input | 4 | Address strap bits, lowest four address bits |
| reg_addr | output | 2 | Current register pointer |
| reg_wdata | output | 8 | Data byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for the register at `reg_addr` |

## Verification
A corrupted pointer shows up on `reg_addr` within a few clock cycles of the acknowledge that changed it, because the pointer is visible between transfers. It then shows up again in the first read byte, which comes from the wrong register. A wrong acceptance decision shows up on SDA in the very next acknowledge clock, and for writes also as a missing or extra `reg_we` pulse in that byte. A transfer state machine stuck after a NACK shows up as SDA pulled low during bits the master expects to read as ones.

// File: rtl/i2c_ptr_regif_pkg.sv
// Shared types and helpers for the I2C pointer register interface.
// Assumes: byte-wide registers, a pointer held in the low command bits.
package i2c_ptr_regif_pkg;

    localparam int BYTE_W = 8;

    // Transfer phases of the serial controller
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } xfer_state_t;

    // Command byte check: only pointer bits and the increment flag may be set,
    // and the pointer must name an existing register.
    function automatic logic cmd_is_valid(input logic [BYTE_W-1:0] b,
                                          input int ptr_w,
                                          input int ai_bit,
                                          input int nregs);
        int p;
        p = 0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < ptr_w) begin
                if (b[i]) p = p + (1 << i);
            end else if (i != ai_bit && b[i]) begin
                return 1'b0;
            end
        end
        return (p < nregs);
    endfunction

endpackage

// File: rtl/i2c_ptr_regif_lines.sv
// Bus condition detector.
// Compares the current SCL/SDA samples with the previous ones and reports
// clock edges, START and STOP as single-cycle pulses.
// Assumes inputs are already synchronised to clk and glitch free.
module i2c_ptr_regif_lines (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Remember the previous line levels; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_ptr_regif_ptr.sv
// Command register: holds the register pointer and auto-increment flag.
// Loads from an accepted command byte. Advances with wrap on the read path
// and with saturation on the write path, only while the flag is set.
// Assumes load and advance requests never coincide.
module i2c_ptr_regif_ptr #(
    parameter int PTR_W    = 2,
    parameter int NUM_REGS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             load_ai,
    input  logic             adv_rd,
    input  logic             adv_wr,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             ai_q;

    // Pointer and flag update: load, read wrap, write saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ai_q  <= 1'b0;
        end else if (load) begin
            ptr_q <= load_ptr;
            ai_q  <= load_ai;
        end else if (ai_q && adv_rd) begin
            ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end else if (ai_q && adv_wr && ptr_q != LAST_IDX) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/i2c_ptr_regif_xfer.sv
// Serial transfer controller.
// Shifts bytes in on SCL rising edges, decides ACK/NACK at the eighth bit,
// drives acknowledge and read data on SCL falling edges, and issues
// command-load, write and read-advance pulses one cycle after each decision.
// Assumes each SCL phase lasts at least two clk cycles.
module i2c_ptr_regif_xfer
    import i2c_ptr_regif_pkg::*;
#(
    parameter int         STRAP_W   = 4,
    parameter logic [6:0] ADDR_BASE = 7'h70,
    parameter int         PTR_W     = 2,
    parameter int         NUM_REGS  = 3,
    parameter int         RO_IDX    = 2,
    parameter int         AI_BIT    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_i,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [BYTE_W-1:0]  rdata,
    output logic               sda_oe,
    output logic               we,
    output logic [BYTE_W-1:0]  wdata,
    output logic               cmd_load,
    output logic [PTR_W-1:0]   cmd_ptr,
    output logic               cmd_ai,
    output logic               adv_rd
);

    localparam logic [6:0]       BASE_MASK = 7'h7F << STRAP_W;
    localparam logic [PTR_W-1:0] RO_PTR    = PTR_W'(RO_IDX);
    localparam int               CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(BYTE_W);

    xfer_state_t       state_q;
    xfer_state_t       next_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              ack_phase_q;
    logic              sda_oe_q;
    logic              we_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              cmd_load_q;
    logic [PTR_W-1:0]  cmd_ptr_q;
    logic              cmd_ai_q;
    logic              adv_rd_q;

    logic [BYTE_W-1:0] rx_byte;
    logic [6:0]        own_addr;
    logic              addr_hit;
    logic              cmd_ok;

    // Byte assembled with the bit arriving now, and acceptance tests on it.
    always_comb begin
        rx_byte  = {shreg_q[BYTE_W-2:0], sda_i};
        own_addr = (ADDR_BASE & BASE_MASK) | 7'(strap);
        addr_hit = (rx_byte[BYTE_W-1:1] == own_addr);
        cmd_ok   = cmd_is_valid(rx_byte, PTR_W, AI_BIT, NUM_REGS);
    end

    // Transfer sequencing, SDA drive and register-bus pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            next_q      <= ST_IDLE;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ack_phase_q <= 1'b0;
            sda_oe_q    <= 1'b0;
            we_q        <= 1'b0;
            wdata_q     <= '0;
            cmd_load_q  <= 1'b0;
            cmd_ptr_q   <= '0;
            cmd_ai_q    <= 1'b0;
            adv_rd_q    <= 1'b0;
        end else begin
            we_q       <= 1'b0;
            cmd_load_q <= 1'b0;
            adv_rd_q   <= 1'b0;
            if (start_det) begin
                state_q     <= ST_ADDR;
                bit_cnt_q   <= '0;
                ack_phase_q <= 1'b0;
                sda_oe_q    <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg_q   <= rx_byte;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                bit_cnt_q   <= '0;
                                ack_phase_q <= 1'b0;
                                state_q     <= ST_SKIP;
                                if (state_q == ST_ADDR && addr_hit) begin
                                    state_q <= ST_ACK;
                                    next_q  <= rx_byte[0] ? ST_RDATA : ST_CMD;
                                end else if (state_q == ST_CMD && cmd_ok) begin
                                    state_q    <= ST_ACK;
                                    next_q     <= ST_WDATA;
                                    cmd_load_q <= 1'b1;
                                    cmd_ptr_q  <= rx_byte[PTR_W-1:0];
                                    cmd_ai_q   <= rx_byte[AI_BIT];
                                end else if (state_q == ST_WDATA && ptr != RO_PTR) begin
                                    state_q <= ST_ACK;
                                    next_q  <= ST_WDATA;
                                    we_q    <= 1'b1;
                                    wdata_q <= rx_byte;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_phase_q) begin
                                sda_oe_q    <= 1'b1;
                                ack_phase_q <= 1'b1;
                            end else begin
                                ack_phase_q <= 1'b0;
                                bit_cnt_q   <= '0;
                                state_q     <= next_q;
                                if (next_q == ST_RDATA) begin
                                    shreg_q  <= rdata;
                                    sda_oe_q <= ~rdata[BYTE_W-1];
                                end else begin
                                    sda_oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == FULL_CNT) begin
                                sda_oe_q  <= 1'b0;
                                bit_cnt_q <= '0;
                                state_q   <= ST_RACK;
                            end else begin
                                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~shreg_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            adv_rd_q <= 1'b1;
                            state_q  <= sda_i ? ST_SKIP : ST_RNEXT;
                        end
                    end
                    ST_RNEXT: begin
                        if (scl_fall) begin
                            shreg_q   <= rdata;
                            sda_oe_q  <= ~rdata[BYTE_W-1];
                            bit_cnt_q <= '0;
                            state_q   <= ST_RDATA;
                        end
                    end
                    default: begin
                        sda_oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe   = sda_oe_q;
    assign we       = we_q;
    assign wdata    = wdata_q;
    assign cmd_load = cmd_load_q;
    assign cmd_ptr  = cmd_ptr_q;
    assign cmd_ai   = cmd_ai_q;
    assign adv_rd   = adv_rd_q;

endmodule

// File: rtl/i2c_ptr_regif.sv
// Top of the I2C pointer register interface.
// Connects the line detector, transfer controller and command register,
// and exposes the pointer as the register-bus address.
// Assumes SCL/SDA are synchronised and registers answer combinationally.
module i2c_ptr_regif
    import i2c_ptr_regif_pkg::*;
#(
    parameter int         STRAP_W   = 4,
    parameter logic [6:0] ADDR_BASE = 7'h70,
    parameter int         PTR_W     = 2,
    parameter int         NUM_REGS  = 3,
    parameter int         RO_IDX    = 2,
    parameter int         AI_BIT    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [PTR_W-1:0]   reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we,
    input  logic [BYTE_W-1:0]  reg_rdata
);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             cmd_load;
    logic [PTR_W-1:0] cmd_ptr;
    logic             cmd_ai;
    logic             adv_rd;
    logic [PTR_W-1:0] ptr;

    i2c_ptr_regif_lines u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ptr_regif_xfer #(
        .STRAP_W   (STRAP_W),
        .ADDR_BASE (ADDR_BASE),
        .PTR_W     (PTR_W),
        .NUM_REGS  (NUM_REGS),
        .RO_IDX    (RO_IDX),
        .AI_BIT    (AI_BIT)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .ptr       (ptr),
        .rdata     (reg_rdata),
        .sda_oe    (sda_oe),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .cmd_load  (cmd_load),
        .cmd_ptr   (cmd_ptr),
        .cmd_ai    (cmd_ai),
        .adv_rd    (adv_rd)
    );

    // Write advance is taken from the strobe so the address holds during it.
    i2c_ptr_regif_ptr #(
        .PTR_W    (PTR_W),
        .NUM_REGS (NUM_REGS)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .load_ptr (cmd_ptr),
        .load_ai  (cmd_ai),
        .adv_rd   (adv_rd),
        .adv_wr   (reg_we),
        .ptr      (ptr)
    );

    assign reg_addr = ptr;

endmodule

// File: rtl/i2c_ptr_regif_chk.sv
// Port-level property checker for i2c_ptr_regif, attached by bind.
// Assumes SCL high and low phases last at least two clk cycles.
module i2c_ptr_regif_chk #(
    parameter int PTR_W  = 2,
    parameter int RO_IDX = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             sda_oe,
    input logic [PTR_W-1:0] reg_addr,
    input logic             reg_we
);

    // R4: the read-only register never receives a write strobe
    a_r4_no_ro_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr != PTR_W'(RO_IDX)));

    // R3: one accepted byte gives a single-cycle strobe
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: the strobe falls inside the high phase of the eighth data clock
    a_r3_strobe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> scl_i);

    // R9: SDA is only pulled low while SCL is low
    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R9: a START seen on the lines releases SDA
    a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_oe);

    // R9: a STOP seen on the lines releases SDA
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);

endmodule

bind i2c_ptr_regif i2c_ptr_regif_chk #(
    .PTR_W  (PTR_W),
    .RO_IDX (RO_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_we   (reg_we)
);

// File: tb/sim_i2c_ptr_regif.sv
`timescale 1ns/1ps
// Bench: bit-banged I2C master, behavioural register file, sweeps of every
// address and every command byte plus directed read/write sequences.
module sim_i2c_ptr_regif;

    localparam int Q = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] strap = 4'h6;
    logic       sda_oe;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       bus_sda;

    logic [7:0] rm [0:3];
    int         we_cnt = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign bus_sda   = m_sda & ~sda_oe;
    assign reg_rdata = rm[reg_addr];

    i2c_ptr_regif u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (bus_sda),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // Behavioural register file and strobe counter
    always @(posedge clk) begin
        if (reg_we) begin
            rm[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = bus_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            rbit(r);
            b[i] = r;
        end
        wbit(!m_ack);
    endtask

    // Address 111_0110 with strap 6
    localparam logic [7:0] AW = 8'hEC;
    localparam logic [7:0] AR = 8'hED;

    initial begin
        logic       ack;
        logic [7:0] d;
        int         base;
        int         exp_ptr;
        logic       ok;

        rm[0] <= 8'h00; rm[1] <= 8'h00; rm[2] <= 8'h00; rm[3] <= 8'hEE;
        tick(4);
        // R10 / R8: reset state
        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 reg_we", reg_we, 0);
        chk("R8 reset pointer", reg_addr, 0);
        rst_n = 1'b1;
        tick(4);

        // R1: every write-direction address under two strap settings
        for (int s = 0; s < 2; s++) begin
            strap = (s == 0) ? 4'h5 : 4'hA;
            tick(2);
            for (int a = 0; a < 128; a++) begin
                i2c_start();
                send_byte({a[6:0], 1'b0}, ack);
                i2c_stop();
                chk("R1 address ack", ack, (a == (32'h70 | 32'(strap))) ? 1 : 0);
                chk("R9 released after stop", sda_oe, 0);
            end
        end
        strap = 4'h6;
        tick(2);

        // R1: read-direction address mismatch is not acknowledged
        i2c_start();
        send_byte(8'hE1, ack);
        chk("R1 read mismatch", ack, 0);
        i2c_stop();

        // R1: after a mismatch, later bytes are ignored
        base = we_cnt;
        i2c_start();
        send_byte(8'hE0, ack);
        chk("R1 mismatch nack", ack, 0);
        send_byte(8'h01, ack);
        chk("R1 ignored cmd", ack, 0);
        send_byte(8'h77, ack);
        chk("R1 ignored data", ack, 0);
        i2c_stop();
        chk("R1 no strobe", we_cnt - base, 0);
        chk("R1 pointer kept", reg_addr, 0);

        // R2: every command byte value
        exp_ptr = 0;
        for (int c = 0; c < 256; c++) begin
            i2c_start();
            send_byte(AW, ack);
            chk("R2 address ack", ack, 1);
            send_byte(c[7:0], ack);
            i2c_stop();
            ok = (c[7:5] == 3'b000) && (c[3:2] == 2'b00) && (c[1:0] != 2'b11);
            if (ok) exp_ptr = c & 3;
            chk("R2 command ack", ack, ok ? 1 : 0);
            chk("R2 stored pointer", reg_addr, exp_ptr);
        end

        // R2: a refused command makes the rest of the transfer ignored
        base = we_cnt;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h03, ack);
        chk("R2 bad cmd nack", ack, 0);
        send_byte(8'h99, ack);
        chk("R2 data after bad cmd", ack, 0);
        i2c_stop();
        chk("R2 no strobe", we_cnt - base, 0);

        // R5 / R4: auto-increment write saturates at the status register
        base = we_cnt;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h10, ack);
        chk("R5 cmd ack", ack, 1);
        send_byte(8'h11, ack);
        chk("R5 byte0 ack", ack, 1);
        send_byte(8'h22, ack);
        chk("R5 byte1 ack", ack, 1);
        send_byte(8'h33, ack);
        chk("R4 status write nack", ack, 0);
        i2c_stop();
        chk("R5 reg0", rm[0], 8'h11);
        chk("R5 reg1", rm[1], 8'h22);
        chk("R4 status untouched", rm[2], 8'h00);
        chk("R5 strobes", we_cnt - base, 2);
        chk("R5 pointer saturates", reg_addr, 2);

        // R5: start at 01, second byte lands on status and is refused
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h11, ack);
        send_byte(8'h44, ack);
        chk("R5 ack at 01", ack, 1);
        send_byte(8'h55, ack);
        chk("R4 nack at 10", ack, 0);
        i2c_stop();
        chk("R5 reg1 second", rm[1], 8'h44);
        chk("R5 no wrap", reg_addr, 2);

        // R3: no auto-increment rewrites the same register
        base = we_cnt;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h01, ack);
        send_byte(8'h5A, ack);
        chk("R3 first ack", ack, 1);
        send_byte(8'h6B, ack);
        chk("R3 second ack", ack, 1);
        i2c_stop();
        chk("R3 reg1", rm[1], 8'h6B);
        chk("R3 reg0 kept", rm[0], 8'h11);
        chk("R3 strobes", we_cnt - base, 2);
        chk("R3 pointer", reg_addr, 1);

        // R4: direct status write
        base = we_cnt;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h02, ack);
        chk("R4 cmd ack", ack, 1);
        send_byte(8'hA5, ack);
        chk("R4 nack", ack, 0);
        i2c_stop();
        chk("R4 no strobe", we_cnt - base, 0);

        // R6: auto-increment read wraps 10 -> 00
        rm[0] <= 8'h3C; rm[1] <= 8'h96; rm[2] <= 8'hC3;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h10, ack);
        i2c_stop();
        i2c_start();
        send_byte(AR, ack);
        chk("R6 read address ack", ack, 1);
        recv_byte(1'b1, d); chk("R6 read reg0", d, 8'h3C);
        recv_byte(1'b1, d); chk("R6 read reg1", d, 8'h96);
        recv_byte(1'b1, d); chk("R6 read reg2", d, 8'hC3);
        recv_byte(1'b0, d); chk("R6 wrap to reg0", d, 8'h3C);
        i2c_stop();
        chk("R8 pointer after read", reg_addr, 1);

        // R8: a new read begins at the stored pointer
        i2c_start();
        send_byte(AR, ack);
        recv_byte(1'b0, d);
        chk("R8 read from stored pointer", d, 8'h96);
        i2c_stop();

        // R6: without auto-increment the same register repeats
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h02, ack);
        i2c_stop();
        i2c_start();
        send_byte(AR, ack);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k < 2, d);
            chk("R6 repeat status", d, 8'hC3);
        end
        i2c_stop();
        chk("R6 pointer held", reg_addr, 2);

        // R8: repeated START keeps the command just written
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h11, ack);
        i2c_start();
        send_byte(AR, ack);
        chk("R8 restart address ack", ack, 1);
        recv_byte(1'b1, d); chk("R8 restart reg1", d, 8'h96);
        recv_byte(1'b0, d); chk("R8 restart reg2", d, 8'hC3);
        i2c_stop();

        // R7: after master NACK the line stays released
        rm[0] <= 8'h00;
        i2c_start();
        send_byte(AW, ack);
        send_byte(8'h00, ack);
        i2c_stop();
        i2c_start();
        send_byte(AR, ack);
        recv_byte(1'b0, d);
        chk("R7 zero byte", d, 8'h00);
        recv_byte(1'b0, d);
        chk("R7 released after nack", d, 8'hFF);
        i2c_stop();
        chk("R9 released at end", sda_oe, 0);

        summary();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

endmodule